// File: doc/BRIEF.md
# Timer Event Flag Register

This block collects four timer events into a status register and raises one interrupt request from them. It has its own 16-bit free-running counter and a real-time tick divider with four selectable periods. It also accepts two single-cycle strobes from an external pulse accumulator: one for accumulator overflow and one for an accumulator input edge. Each event latches a sticky flag. Software clears a flag by writing a one to its bit.

A second register holds one enable bit for each flag, in the same bit positions as the flags, plus the two-bit tick rate. The interrupt request is high while any flag is set and its enable bit is also set. Flags latch whether or not they are enabled, so the block works both for polling and for interrupt-driven software.

The register bus is a plain control port with no back-pressure. A write is a one-cycle strobe that takes effect at the clock edge. Read data is combinational from the select input. The block has no streaming data path, so it has no valid/ready handshake.

Top module: `tmr_evflag`

## Requirements
- R1: After reset, the flag register reads 0x00, the enable register reads 0x00, `timer_count` is 0 and `irq_req` is low.
- R2: With `bus_sel`=0 the bus reads the flag register. Its bits are assigned as follows: bit 7 is counter wrap, bit 6 is tick, bit 5 is accumulator overflow and bit 4 is accumulator edge. Bits 3..0 always read 0.
- R3: A write with `bus_sel`=0 clears each flag whose bit in `bus_wdata[7:4]` is 1. Flags whose bit is 0 are left unchanged, and `bus_wdata[3:0]` has no effect.
- R4: Flag bit 7 becomes 1 on the clock edge at which `timer_count` steps from 0xFFFF to 0x0000.
- R5: A write with `bus_sel`=1 restarts the tick divider. Flag bit 6 then becomes 1 exactly 2^(13+rate) clock edges after that write edge, where rate is enable-register bits 1..0. It then sets again every 2^(13+rate) edges.
- R6: A high `pa_ovf_evt` sets flag bit 5 at the next edge. A high `pa_edge_evt` sets flag bit 4 at the next edge.
- R7: With `bus_sel`=1 the bus reads the enable register. Bits 7..4 are the enables, in the same positions as the flags. Bits 1..0 are the rate. Bits 3..2 always read 0.
- R8: `irq_req` is high exactly while some flag and its enable bit are both 1. It stays high until software clears the flag or the enable bit.
- R9: When a flag's event and a write-one-to-clear of that flag fall in the same cycle, the flag ends up set.
- R10: Flags latch regardless of their enable bits. A disabled flag does not drive `irq_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_sel | input | 1 | Register select: 0 flags, 1 enables |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the selected register |
| pa_ovf_evt | input | 1 | Accumulator overflow strobe |
| pa_edge_evt | input | 1 | Accumulator input-edge strobe |
| timer_count | output | 16 | Free-running counter value |
| irq_req | output | 1 | Combined interrupt request |

## Verification
The bench drives an event strobe and a clear of the same flag in one cycle. A design that lets the clear win would lose the event, and the flag would read 0. It writes zero bits and low-nibble bits to the flag register; a design that cleared on any write, or decoded the wrong nibble, would drop flags that should stay set. It measures the tick period to the exact edge at two rates, and watches the counter wrap from 0xFFFF. An off-by-one divider, or a wrong rate decode, would set bit 6 one period or one cycle away from the expected edge. It also toggles enable bits while flags are set, which catches a request tied to the raw flags, as well as readback that leaks the unused bits.

// File: rtl/tef_pkg.sv
package tef_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned BUS_W     = 8;
  // position of each event inside the upper nibble (bit 4 + index on the bus)
  localparam int unsigned IDX_WRAP  = 3;
  localparam int unsigned IDX_TICK  = 2;
  localparam int unsigned IDX_ACOV  = 1;
  localparam int unsigned IDX_ACED  = 0;
  localparam int unsigned FLAG_LSB  = BUS_W - NUM_FLAGS;

  typedef enum logic {
    SEL_FLAGS  = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tef_free_counter.sv
module tef_free_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count,
  output logic             wrap_pulse
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  // high in the cycle whose closing edge rolls the count back to zero
  assign wrap_pulse = (cnt_q == {CNT_W{1'b1}});
  assign count      = cnt_q;
endmodule

// File: rtl/tef_rti_divider.sv
module tef_rti_divider #(
  parameter int unsigned BASE_LOG2 = 13,
  parameter int unsigned RATE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int unsigned DIV_W = BASE_LOG2 + (1 << RATE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last_val;

  // terminal count for the selected period 2^(BASE_LOG2+rate)
  always_comb begin
    last_val = '0;
    for (int i = 0; i < (1 << RATE_W); i++) begin
      if (rate == RATE_W'(i)) last_val = {DIV_W{1'b1}} >> ((1 << RATE_W) - 1 - i);
    end
  end

  assign tick = (div_q == last_val) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tef_flag_bank.sv
module tef_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          f_q <= 1'b0;
      else if (set_vec[g]) f_q <= 1'b1;   // event beats a same-cycle clear
      else if (clr_vec[g]) f_q <= 1'b0;
    end
    assign flags[g] = f_q;
  end
endmodule

// File: rtl/tmr_evflag.sv
module tmr_evflag
  import tef_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned TICK_LOG2 = 13,
  parameter int unsigned RATE_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             pa_ovf_evt,
  input  logic             pa_edge_evt,
  output logic [CNT_W-1:0] timer_count,
  output logic             irq_req
);
  localparam int unsigned PAD_W = FLAG_LSB - RATE_W;

  logic                 wr_flags, wr_enable;
  logic                 wrap_pulse, tick;
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flags_q, en_q;
  logic [RATE_W-1:0]    rate_q;
  logic                 unused_wbits;

  assign wr_flags  = bus_wr && (reg_sel_e'(bus_sel) == SEL_FLAGS);
  assign wr_enable = bus_wr && (reg_sel_e'(bus_sel) == SEL_ENABLE);

  tef_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (timer_count),
    .wrap_pulse (wrap_pulse)
  );

  tef_rti_divider #(.BASE_LOG2(TICK_LOG2), .RATE_W(RATE_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (wr_enable),
    .rate    (rate_q),
    .tick    (tick)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[IDX_WRAP] = wrap_pulse;
    set_vec[IDX_TICK] = tick;
    set_vec[IDX_ACOV] = pa_ovf_evt;
    set_vec[IDX_ACED] = pa_edge_evt;
  end

  assign clr_vec = wr_flags ? bus_wdata[BUS_W-1:FLAG_LSB] : '0;

  tef_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flags   (flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      rate_q <= '0;
    end else if (wr_enable) begin
      en_q   <= bus_wdata[BUS_W-1:FLAG_LSB];
      rate_q <= bus_wdata[RATE_W-1:0];
    end
  end

  assign unused_wbits = ^bus_wdata[FLAG_LSB-1:RATE_W];

  always_comb begin
    if (reg_sel_e'(bus_sel) == SEL_ENABLE) bus_rdata = {en_q, {PAD_W{1'b0}}, rate_q};
    else                                   bus_rdata = {flags_q, {FLAG_LSB{1'b0}}};
  end

  assign irq_req = |(flags_q & en_q);
endmodule

// File: rtl/tmr_evflag_chk.sv
module tmr_evflag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_sel,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic        pa_ovf_evt,
  input logic        pa_edge_evt,
  input logic [15:0] timer_count,
  input logic        irq_req,
  input logic [3:0]  flags_q
);
  assert_low_nibble_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> bus_rdata[3:0] == 4'h0);

  assert_unused_enable_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |-> bus_rdata[3:2] == 2'b00);

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_sel && bus_wdata[5] && !pa_ovf_evt |=> !flags_q[1]);

  assert_zero_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_sel |=>
      ((flags_q & $past(flags_q & ~bus_wdata[7:4])) == $past(flags_q & ~bus_wdata[7:4])));

  assert_wrap_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timer_count == 16'hFFFF |=> flags_q[3] && timer_count == 16'h0000);

  assert_acc_ovf_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pa_ovf_evt |=> flags_q[1]);

  assert_acc_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pa_edge_evt && bus_wr && !bus_sel && bus_wdata[4] |=> flags_q[0]);

  assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !bus_wr |=> irq_req);
endmodule

bind tmr_evflag tmr_evflag_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_wr      (bus_wr),
  .bus_sel     (bus_sel),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pa_ovf_evt  (pa_ovf_evt),
  .pa_edge_evt (pa_edge_evt),
  .timer_count (timer_count),
  .irq_req     (irq_req),
  .flags_q     (flags_q)
);

// File: tb/tmr_evflag_bench.sv
module tmr_evflag_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        pa_ovf_evt = 1'b0;
  logic        pa_edge_evt = 1'b0;
  logic [15:0] timer_count;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tmr_evflag u_tmr_evflag (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_ovf_evt(pa_ovf_evt),
    .pa_edge_evt(pa_edge_evt), .timer_count(timer_count), .irq_req(irq_req)
  );

  typedef struct packed {
    logic       wr;
    logic       sel;
    logic [7:0] wd;
    logic       aov;
    logic       aed;
    logic [7:0] exp_flags;
    logic       exp_irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'h30, 1'b0, 1'b0, 8'h00, 1'b0},  // R7 enable both acc flags
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h20, 1'b1},  // R6 overflow strobe
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h30, 1'b1},  // R6 edge strobe
    '{1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h30, 1'b1},  // R3 zero write keeps
    '{1'b1, 1'b0, 8'h20, 1'b0, 1'b0, 8'h10, 1'b1},  // R3 clear bit 5
    '{1'b1, 1'b0, 8'h0F, 1'b0, 1'b0, 8'h10, 1'b1},  // R3 low nibble ignored
    '{1'b1, 1'b0, 8'h10, 1'b0, 1'b1, 8'h10, 1'b1},  // R9 set beats clear
    '{1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 8'h00, 1'b0},  // R3 clear bit 4
    '{1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 8'h20, 1'b0},  // R10 latch while disabled
    '{1'b1, 1'b1, 8'h20, 1'b0, 1'b0, 8'h20, 1'b1},  // R8 enable raises request
    '{1'b1, 1'b1, 8'h10, 1'b0, 1'b0, 8'h20, 1'b0},  // R8 disable drops request
    '{1'b1, 1'b0, 8'hF0, 1'b0, 1'b0, 8'h00, 1'b0}   // R3 clear all
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive for one edge starting at a negedge, return at the following negedge idle
  task automatic bus_write(input logic sel, input logic [7:0] wd);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = wd;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_sel = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic idle_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_flags(output logic [7:0] v);
    bus_sel = 1'b0; #1; v = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // measure the tick period for a given rate; the write edge counts as edge 0
  task automatic tick_test(input logic [1:0] rate, input string req);
    int period = 1 << (13 + rate);
    logic [7:0] v;
    bus_write(1'b1, {4'h4, 2'b00, rate});          // edge 0
    bus_write(1'b0, 8'h40);                        // edge 1, clear stale tick flag
    idle_edges(period - 2);                        // through edge period-1
    read_flags(v); check({req, " tick not early"}, 32'(v[6]), 32'd0);
    idle_edges(1);                                 // edge period
    read_flags(v); check({req, " tick at period"}, 32'(v[6]), 32'd1);
    check({"R8 tick request ", req}, 32'(irq_req), 32'd1);
    bus_write(1'b0, 8'h40);                        // edge period+1
    idle_edges(period - 2);                        // through edge 2*period-1
    read_flags(v); check({req, " second tick not early"}, 32'(v[6]), 32'd0);
    idle_edges(1);                                 // edge 2*period
    read_flags(v); check({req, " periodic tick"}, 32'(v[6]), 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_flags(v); check("R1 flags after reset", 32'(v), 32'h00);
    bus_sel = 1'b1; #1; check("R1 enables after reset", 32'(bus_rdata), 32'h00);
    bus_sel = 1'b0;
    check("R1 counter after reset", 32'(timer_count), 32'h0);
    check("R1 request after reset", 32'(irq_req), 32'd0);
    @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++) begin
      bus_wr = VECS[i].wr; bus_sel = VECS[i].sel; bus_wdata = VECS[i].wd;
      pa_ovf_evt = VECS[i].aov; pa_edge_evt = VECS[i].aed;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 8'h00; pa_ovf_evt = 1'b0; pa_edge_evt = 1'b0;
      read_flags(v);
      check($sformatf("R2/R3/R6/R9 vector %0d flags", i), 32'(v), 32'(VECS[i].exp_flags));
      check($sformatf("R8/R10 vector %0d request", i), 32'(irq_req), 32'(VECS[i].exp_irq));
      @(negedge clk);
    end

    // R7 enable readback masks unused bits
    bus_write(1'b1, 8'hFF);
    bus_sel = 1'b1; #1; check("R7 enable readback", 32'(bus_rdata), 32'hF3);
    bus_sel = 1'b0;
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'hF0);

    // R5 tick timing at two rates
    tick_test(2'd0, "R5 rate0");
    tick_test(2'd1, "R5 rate1");

    // R4 counter wrap
    bus_write(1'b1, 8'h80);
    bus_write(1'b0, 8'hF0);
    while (timer_count != 16'hFFFF) @(negedge clk);
    read_flags(v); check("R4 no wrap flag before roll", 32'(v[7]), 32'd0);
    @(posedge clk); @(negedge clk);
    check("R4 counter rolled", 32'(timer_count), 32'h0000);
    read_flags(v); check("R4 wrap flag set", 32'(v[7]), 32'd1);
    check("R8 wrap request", 32'(irq_req), 32'd1);
    bus_write(1'b0, 8'h80);
    read_flags(v); check("R3 wrap flag cleared", 32'(v[7]), 32'd0);
    check("R8 request dropped", 32'(irq_req), 32'd0);

    finish_run();
  end
endmodule